// File: doc/BRIEF.md
# Ownership Directory Slice with Fixed Address Partition

This block is the directory slice that one node keeps in a shared-memory system where every address has a manager chosen by a fixed partition of the address space. Node `NODE_ID` manages the contiguous group of `ADDRS_PER_NODE` addresses that starts at `NODE_ID * ADDRS_PER_NODE`. For each of these addresses the slice keeps two things: the ID of the node that owns the block, and a bit vector with bit *i* set when node *i* holds a read copy.

A request carries a read/write flag, an address and the requester's node ID. The slice looks up the entry and answers with the owner the requester must contact for the data. A read adds the requester to the sharer vector. A write hands ownership to the writer and clears the sharer vector in the same table update. It also produces the set of nodes whose copies must be invalidated: the old sharers with the writer's own bit removed. The transfer of data and the network are handled outside this block.

The controller is a five-state machine:
- `ST_IDLE` accepts a request.
- `ST_LOOKUP` snapshots the entry.
- `ST_COMMIT` writes the updated entry.
- `ST_REPLY` presents the response and any invalidation.
- `ST_REJECT` presents an error response.

Its transitions are:
- idle→lookup on an in-range request.
- idle→reject on an out-of-range one.
- lookup→commit, commit→reply, reply→idle and reject→idle unconditionally.

Top module: `owndir_slice`

## Requirements
- R1: After reset, every managed address is owned by `NODE_ID` and has an empty sharer vector. `req_ready` is 1, and `rsp_valid`, `inv_valid` and `inv_mask` are 0.
- R2: A request whose address lies outside `[NODE_ID*ADDRS_PER_NODE, (NODE_ID+1)*ADDRS_PER_NODE)`, or whose `req_src` is not below `NUM_NODES`, is answered with `rsp_valid`=1 and `rsp_err`=1 in the cycle after acceptance. It raises no invalidation and leaves the table unchanged.
- R3: An accepted in-range request is answered with `rsp_valid`=1 and `rsp_err`=0 exactly three cycles after the accepting clock edge. `rsp_owner` gives the owner the entry held before the request.
- R4: A read adds the requester's bit to the sharer vector, unless the requester is the current owner; in that case the vector is unchanged. The owner is unchanged in both cases.
- R5: A write sets the owner to the requester and empties the sharer vector.
- R6: On a write, in the response cycle, `inv_valid`=1 exactly when the old sharer vector with bit `req_src` cleared is non-zero. `inv_mask` then carries that set, with bit *i* standing for node *i*. At all other times `inv_valid`=0 and `inv_mask`=0.
- R7: `req_ready` is 0 from the accepting edge through the response cycle. A request presented while `req_ready` is 0 is ignored.
- R8: `rsp_valid` lasts exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slice can accept a request |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Global address |
| req_src | input | ID_W | Requesting node ID |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Request rejected (address not managed here or bad node ID) |
| rsp_owner | output | ID_W | Owner before the request |
| inv_valid | output | 1 | Invalidation set is present |
| inv_mask | output | NUM_NODES | Nodes to invalidate, one bit per node |

## Verification
On a write, the owner response and the invalidation set leave the slice in the same reply cycle, computed from one snapshot. The bench makes a writer collide with existing sharers, both including and excluding the writer's own bit. It then judges `rsp_owner`, `inv_valid` and `inv_mask` together at that single sample, and confirms the cleared state afterwards with a follow-up write that must raise no invalidation. A second overlap is a new request arriving while a previous one is still in flight. The bench presents a write during a read's lookup and checks both that `req_ready` is low and that a later read still reports the old owner.

// File: rtl/odir_pkg.sv
package odir_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_COMMIT = 3'd2,
        ST_REPLY  = 3'd3,
        ST_REJECT = 3'd4
    } odir_state_e;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } odir_op_e;

endpackage

// File: rtl/odir_range_decode.sv
module odir_range_decode #(
    parameter int NUM_NODES      = 3,
    parameter int ADDRS_PER_NODE = 3,
    parameter int NODE_ID        = 1,
    localparam int ADDR_W = $clog2(NUM_NODES * ADDRS_PER_NODE),
    localparam int ID_W   = $clog2(NUM_NODES),
    localparam int IDX_W  = (ADDRS_PER_NODE > 1) ? $clog2(ADDRS_PER_NODE) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ID_W-1:0]   src,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0] BASE_W  = (ADDR_W+1)'(NODE_ID * ADDRS_PER_NODE);
    localparam logic [ADDR_W:0] LIMIT_W = (ADDR_W+1)'((NODE_ID + 1) * ADDRS_PER_NODE);
    localparam logic [ID_W:0]   NODES_W = (ID_W+1)'(NUM_NODES);

    logic [ADDR_W:0] addr_w;
    logic [ADDR_W:0] offset_w;
    logic            addr_ok;
    logic            src_ok;

    always_comb begin
        addr_w   = {1'b0, addr};
        offset_w = addr_w - BASE_W;
        addr_ok  = (addr_w >= BASE_W) && (addr_w < LIMIT_W);
        src_ok   = ({1'b0, src} < NODES_W);
        hit      = addr_ok && src_ok;
        idx      = addr_ok ? offset_w[IDX_W-1:0] : '0;
    end
endmodule

// File: rtl/odir_entry_table.sv
module odir_entry_table #(
    parameter int NUM_NODES      = 3,
    parameter int ADDRS_PER_NODE = 3,
    parameter int NODE_ID        = 1,
    localparam int ID_W  = $clog2(NUM_NODES),
    localparam int IDX_W = (ADDRS_PER_NODE > 1) ? $clog2(ADDRS_PER_NODE) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [ID_W-1:0]      rd_owner,
    output logic [NUM_NODES-1:0] rd_sharers,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [ID_W-1:0]      wr_owner,
    input  logic [NUM_NODES-1:0] wr_sharers
);
    localparam logic [ID_W-1:0] HOME_ID = ID_W'(NODE_ID);

    logic [ID_W-1:0]      owner_q   [ADDRS_PER_NODE];
    logic [NUM_NODES-1:0] sharers_q [ADDRS_PER_NODE];

    for (genvar e = 0; e < ADDRS_PER_NODE; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                owner_q[e]   <= HOME_ID;
                sharers_q[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                owner_q[e]   <= wr_owner;
                sharers_q[e] <= wr_sharers;
            end
        end
    end

    always_comb begin
        rd_owner   = HOME_ID;
        rd_sharers = '0;
        for (int e = 0; e < ADDRS_PER_NODE; e++) begin
            if (rd_idx == IDX_W'(e)) begin
                rd_owner   = owner_q[e];
                rd_sharers = sharers_q[e];
            end
        end
    end
endmodule

// File: rtl/odir_ctrl_fsm.sv
module odir_ctrl_fsm
    import odir_pkg::*;
#(
    parameter int NUM_NODES      = 3,
    parameter int ADDRS_PER_NODE = 3,
    localparam int ID_W  = $clog2(NUM_NODES),
    localparam int IDX_W = (ADDRS_PER_NODE > 1) ? $clog2(ADDRS_PER_NODE) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_hit,
    input  logic [IDX_W-1:0]     req_idx,
    input  logic [ID_W-1:0]      req_src,
    output logic                 req_ready,
    output logic [IDX_W-1:0]     rd_idx,
    input  logic [ID_W-1:0]      rd_owner,
    input  logic [NUM_NODES-1:0] rd_sharers,
    output logic                 wr_en,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [ID_W-1:0]      wr_owner,
    output logic [NUM_NODES-1:0] wr_sharers,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [ID_W-1:0]      rsp_owner,
    output logic                 inv_valid,
    output logic [NUM_NODES-1:0] inv_mask
);
    odir_state_e          state_q, state_d;
    odir_op_e             op_q;
    logic [IDX_W-1:0]     idx_q;
    logic [ID_W-1:0]      src_q;
    logic [ID_W-1:0]      owner_q;
    logic [NUM_NODES-1:0] sharers_q;
    logic [NUM_NODES-1:0] src_bit;
    logic [NUM_NODES-1:0] others;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = req_hit ? ST_LOOKUP : ST_REJECT;
            ST_LOOKUP: state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request capture and entry snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_READ;
            idx_q     <= '0;
            src_q     <= '0;
            owner_q   <= '0;
            sharers_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                op_q  <= req_write ? OP_WRITE : OP_READ;
                idx_q <= req_idx;
                src_q <= req_src;
            end
            if (state_q == ST_LOOKUP) begin
                owner_q   <= rd_owner;
                sharers_q <= rd_sharers;
            end
        end
    end

    always_comb begin
        src_bit = NUM_NODES'(1) << src_q;
        others  = sharers_q & ~src_bit;
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        rd_idx     = idx_q;
        wr_en      = 1'b0;
        wr_idx     = idx_q;
        wr_owner   = owner_q;
        wr_sharers = sharers_q;
        rsp_valid  = 1'b0;
        rsp_err    = 1'b0;
        rsp_owner  = '0;
        inv_valid  = 1'b0;
        inv_mask   = '0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_LOOKUP: ;
            ST_COMMIT: begin
                wr_en = 1'b1;
                if (op_q == OP_WRITE) begin
                    wr_owner   = src_q;
                    wr_sharers = '0;
                end else begin
                    wr_owner   = owner_q;
                    wr_sharers = (src_q == owner_q) ? sharers_q : (sharers_q | src_bit);
                end
            end
            ST_REPLY: begin
                rsp_valid = 1'b1;
                rsp_owner = owner_q;
                if (op_q == OP_WRITE && |others) begin
                    inv_valid = 1'b1;
                    inv_mask  = others;
                end
            end
            ST_REJECT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/owndir_slice.sv
module owndir_slice #(
    parameter int NUM_NODES      = 3,
    parameter int ADDRS_PER_NODE = 3,
    parameter int NODE_ID        = 1,
    localparam int ADDR_W = $clog2(NUM_NODES * ADDRS_PER_NODE),
    localparam int ID_W   = $clog2(NUM_NODES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [ID_W-1:0]      req_src,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [ID_W-1:0]      rsp_owner,
    output logic                 inv_valid,
    output logic [NUM_NODES-1:0] inv_mask
);
    localparam int IDX_W = (ADDRS_PER_NODE > 1) ? $clog2(ADDRS_PER_NODE) : 1;

    logic                 hit;
    logic [IDX_W-1:0]     idx;
    logic [IDX_W-1:0]     rd_idx;
    logic [ID_W-1:0]      rd_owner;
    logic [NUM_NODES-1:0] rd_sharers;
    logic                 wr_en;
    logic [IDX_W-1:0]     wr_idx;
    logic [ID_W-1:0]      wr_owner;
    logic [NUM_NODES-1:0] wr_sharers;

    odir_range_decode #(
        .NUM_NODES(NUM_NODES), .ADDRS_PER_NODE(ADDRS_PER_NODE), .NODE_ID(NODE_ID)
    ) u_decode (
        .addr(req_addr), .src(req_src), .hit(hit), .idx(idx)
    );

    odir_entry_table #(
        .NUM_NODES(NUM_NODES), .ADDRS_PER_NODE(ADDRS_PER_NODE), .NODE_ID(NODE_ID)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_owner(rd_owner), .rd_sharers(rd_sharers),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_owner(wr_owner), .wr_sharers(wr_sharers)
    );

    odir_ctrl_fsm #(
        .NUM_NODES(NUM_NODES), .ADDRS_PER_NODE(ADDRS_PER_NODE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_hit(hit),
        .req_idx(idx), .req_src(req_src), .req_ready(req_ready),
        .rd_idx(rd_idx), .rd_owner(rd_owner), .rd_sharers(rd_sharers),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_owner(wr_owner), .wr_sharers(wr_sharers),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_owner(rsp_owner),
        .inv_valid(inv_valid), .inv_mask(inv_mask)
    );
endmodule

// File: rtl/owndir_slice_chk.sv
module owndir_slice_chk #(
    parameter int NUM_NODES = 3,
    localparam int ID_W = $clog2(NUM_NODES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [ID_W-1:0]      req_src,
    input logic                 rsp_valid,
    input logic                 rsp_err,
    input logic                 inv_valid,
    input logic [NUM_NODES-1:0] inv_mask
);
    logic            accept;
    logic [ID_W-1:0] cap_src;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n)      cap_src <= '0;
        else if (accept) cap_src <= req_src;
    end

    // R8
    one_shot_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R7
    reply_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R6
    inv_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (rsp_valid && !rsp_err));

    // R6
    inv_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> ((inv_mask != '0) && (((inv_mask >> cap_src) & NUM_NODES'(1)) == '0)));

    // R6
    idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_valid |-> (inv_mask == '0));

    // R2
    err_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && $past(accept)));

    // R3
    grant_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> $past(accept, 3));
endmodule

bind owndir_slice owndir_slice_chk #(.NUM_NODES(NUM_NODES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .inv_valid(inv_valid), .inv_mask(inv_mask)
);

// File: tb/owndir_slice_bench.sv
`timescale 1ns/1ps
module owndir_slice_bench;
    localparam int NN     = 3;
    localparam int APN    = 3;
    localparam int NID    = 1;
    localparam int ADDR_W = $clog2(NN * APN);
    localparam int ID_W   = $clog2(NN);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [ID_W-1:0]   req_src = '0;
    logic              rsp_valid;
    logic              rsp_err;
    logic [ID_W-1:0]   rsp_owner;
    logic              inv_valid;
    logic [NN-1:0]     inv_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int r_owner, r_err, r_inv, r_mask, r_lat;

    always #4 clk = ~clk;

    owndir_slice #(.NUM_NODES(NN), .ADDRS_PER_NODE(APN), .NODE_ID(NID)) u_owndir_slice (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_src(req_src),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_owner(rsp_owner),
        .inv_valid(inv_valid), .inv_mask(inv_mask)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input int addr, input int src);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = ADDR_W'(addr);
        req_src   = ID_W'(src);
        @(posedge clk);
        r_lat = 0;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            if (n == 1) req_valid = 1'b0;
            if (rsp_valid) begin
                r_lat = n;
                break;
            end
        end
        r_owner = int'(rsp_owner);
        r_err   = int'(rsp_err);
        r_inv   = int'(inv_valid);
        r_mask  = int'(inv_mask);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check_eq("R1 ready after reset", int'(req_ready), 1);
        check_eq("R1 rsp_valid after reset", int'(rsp_valid), 0);
        check_eq("R1 inv_valid after reset", int'(inv_valid), 0);
        check_eq("R1 inv_mask after reset", int'(inv_mask), 0);
        do_req(1'b1, 3, 1);
        check_eq("R1 home owner", r_owner, NID);
        check_eq("R1 empty sharers", r_inv, 0);
        check_eq("R3 latency", r_lat, 3);
        check_eq("R3 no error", r_err, 0);
    endtask

    task automatic t_read_share;
        do_req(1'b0, 4, 0);
        check_eq("R3 read owner", r_owner, 1);
        check_eq("R6 read no inv", r_inv, 0);
        do_req(1'b0, 4, 2);
        check_eq("R3 read owner again", r_owner, 1);
        do_req(1'b1, 4, 0);
        check_eq("R5 prior owner on write", r_owner, 1);
        check_eq("R6 inv_valid", r_inv, 1);
        check_eq("R6 mask drops writer", r_mask, 3'b100);
        do_req(1'b1, 4, 1);
        check_eq("R5 writer became owner", r_owner, 0);
        check_eq("R5 sharers cleared", r_inv, 0);
    endtask

    task automatic t_owner_read;
        do_req(1'b0, 5, 1);
        check_eq("R4 owner reads", r_owner, 1);
        do_req(1'b1, 5, 0);
        check_eq("R4 owner not added", r_inv, 0);
        check_eq("R4 owner kept", r_owner, 1);
    endtask

    task automatic t_errors;
        do_req(1'b0, 2, 0);
        check_eq("R2 below range err", r_err, 1);
        check_eq("R2 err latency", r_lat, 1);
        check_eq("R2 err no inv", r_inv, 0);
        do_req(1'b1, 6, 2);
        check_eq("R2 above range err", r_err, 1);
        do_req(1'b1, 3, 3);
        check_eq("R2 bad src err", r_err, 1);
        do_req(1'b0, 3, 0);
        check_eq("R2 table untouched", r_owner, 1);
        do_req(1'b1, 3, 2);
        check_eq("R2 owner before write", r_owner, 1);
        check_eq("R6 single sharer mask", r_mask, 3'b001);
    endtask

    task automatic t_busy;
        int lat;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = ADDR_W'(5);
        req_src   = ID_W'(1);
        @(posedge clk);
        @(negedge clk);
        check_eq("R7 busy ready low", int'(req_ready), 0);
        req_write = 1'b1;
        req_src   = ID_W'(2);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        for (int n = 0; n < 8; n++) begin
            if (rsp_valid) break;
            @(negedge clk);
            lat++;
        end
        check_eq("R7 in-flight rsp", int'(rsp_valid), 1);
        check_eq("R7 in-flight owner", int'(rsp_owner), 0);
        check_eq("R7 ready low in reply", int'(req_ready), 0);
        @(negedge clk);
        check_eq("R8 single cycle rsp", int'(rsp_valid), 0);
        do_req(1'b0, 5, 0);
        check_eq("R7 ignored write", r_owner, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_share();
        t_owner_read();
        t_errors();
        t_busy();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule